// File: doc/BRIEF.md
# Power and Clock Sequencer for Peripheral Modules

This block owns the power, clock and reset state of eight peripheral modules grouped two to a domain across four power domains. Software selects a target state for each module and a keep-powered flag for each domain through a small memory-mapped register bus. It then writes a command word in which each set bit launches a transition for one domain. A domain that is off when its transition starts is powered up first. Its modules are then moved one after another to their targets, each taking a fixed number of cycles. If nothing in the domain needs power afterwards, the domain is powered down again.

Each module has three derived outputs: a clock enable, an active-low reset and a per-domain power request. These stand in for gating cells, isolation and switches, which are outside the block. Status registers show which domains are busy, whether each domain is powered, and each module's present state and clock activity.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset every module is in state 0, every clock enable and module reset output is 0, every domain is off, no domain is busy and no power request is raised.
- R2: The register map uses byte offsets 0x120 for the write-only command word, 0x128 for busy status, 0x200+4*d for the status of domain d, 0x300+4*d for the control of domain d, 0x800+4*m for the status of module m, and 0xA00+4*m for the control of module m, with m = 2*d + k for module k of domain d.
- R3: In a module control register, bits [1:0] hold the target state (0 reset-off, 1 synchronous reset, 2 disabled, 3 enabled), bits [5:2] of that field read 0, and bit 8 is the local-reset release, which resets to 1; writing 0xFFFFFFFF reads back 0x103.
- R4: Writing 1 to command bit d of an idle domain sets busy bit d for exactly U*SETTLE + 2*STEP + D*SETTLE cycles. U is 1 when the domain was off and D is 1 when a power-down follows; SETTLE is 4 and STEP is 3 by default.
- R5: A command bit aimed at a domain that is already busy is ignored: the transition already in progress keeps its length. A module control write made while its domain is busy does not alter that transition's outcome.
- R6: A domain that is off at the start of a transition is powered up before any module changes. Its status register then reads 1 in bits [4:0], and its power request output is high.
- R7: When a transition ends, the state field in bits [5:0] of each of the domain's module status registers equals the target that was held when the command was accepted.
- R8: Module status bit 12 and the module's clock enable output are 1 exactly when the module is in state 3.
- R9: A module's reset output is 1 exactly when the module is in state 2 or 3 and its local-reset release bit is 1.
- R10: When bit 0 of the domain control register is 0 and every target in the domain is 0, the transition ends by powering the domain down. Its status then reads 0 and its power request output goes low.
- R11: Unmapped offsets, and all bits outside the defined fields, read 0.
- R12: A module's state changes only during a transition of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mod_clk_en | output | 8 | Per-module clock enable |
| mod_rst_n | output | 8 | Per-module active-low reset |
| dom_pwr_req | output | 4 | Per-domain power request |

## Verification
A sequencer that has its phase or counter wrong shows up at once as a busy bit held for the wrong number of cycles. The bench counts this at every cycle of every transition. A target stored or applied wrongly is seen in the module status readback and in the clock-enable and reset pins as soon as the transition completes. A stray change to another domain is caught on the next full sweep of all status registers, which follows every transition. A wrong power flag shows at the domain status and power request pins, both when power-up ends and when the optional power-down ends.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [1:0] {
        MS_RST_OFF  = 2'd0,
        MS_SYNC_RST = 2'd1,
        MS_DISABLE  = 2'd2,
        MS_ENABLE   = 2'd3
    } mstate_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_PWR_UP = 2'd1,
        SQ_WALK   = 2'd2,
        SQ_PWR_DN = 2'd3
    } seq_e;

    localparam int unsigned CMD_OFS   = 32'h120;
    localparam int unsigned BUSY_OFS  = 32'h128;
    localparam int unsigned DSTAT_OFS = 32'h200;
    localparam int unsigned DCTL_OFS  = 32'h300;
    localparam int unsigned MSTAT_OFS = 32'h800;
    localparam int unsigned MCTL_OFS  = 32'hA00;
    localparam int unsigned REG_STRIDE = 4;

    localparam int unsigned MCTL_RLS_BIT  = 8;
    localparam int unsigned MSTAT_CLK_BIT = 12;

endpackage

// File: rtl/psc_dom_seq.sv
module psc_dom_seq
    import psc_pkg::*;
#(
    parameter int MODS   = 2,
    parameter int SETTLE = 4,
    parameter int STEP   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [MODS-1:0][1:0] tgt_i,
    input  logic [MODS-1:0]      rls_i,
    input  logic                 keep_on_i,
    output logic                 busy_o,
    output logic                 dom_on_o,
    output logic                 pwr_req_o,
    output logic [MODS-1:0][1:0] cur_o,
    output logic [MODS-1:0]      clk_en_o,
    output logic [MODS-1:0]      mrst_n_o
);

    localparam int MAXC = (SETTLE > STEP) ? SETTLE : STEP;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int IW   = (MODS > 1) ? $clog2(MODS) : 1;

    typedef struct packed {
        seq_e                 ph;
        logic [CW-1:0]        cnt;
        logic [IW-1:0]        idx;
        logic                 on;
        logic                 pd;
        logic [MODS-1:0][1:0] tgt;
        logic [MODS-1:0][1:0] cur;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            SQ_IDLE: begin
                if (start_i) begin
                    st_d.tgt = tgt_i;
                    st_d.pd  = !keep_on_i && (tgt_i == '0);
                    st_d.cnt = '0;
                    st_d.idx = '0;
                    st_d.ph  = st_q.on ? SQ_WALK : SQ_PWR_UP;
                end
            end
            SQ_PWR_UP: begin
                if (st_q.cnt == CW'(SETTLE - 1)) begin
                    st_d.cnt = '0;
                    st_d.on  = 1'b1;
                    st_d.ph  = SQ_WALK;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            SQ_WALK: begin
                if (st_q.cnt == CW'(STEP - 1)) begin
                    st_d.cur[st_q.idx] = st_q.tgt[st_q.idx];
                    st_d.cnt = '0;
                    if (st_q.idx == IW'(MODS - 1)) begin
                        st_d.idx = '0;
                        st_d.ph  = st_q.pd ? SQ_PWR_DN : SQ_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            SQ_PWR_DN: begin
                if (st_q.cnt == CW'(SETTLE - 1)) begin
                    st_d.cnt = '0;
                    st_d.on  = 1'b0;
                    st_d.ph  = SQ_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = (st_q.ph != SQ_IDLE);
    assign dom_on_o  = st_q.on;
    assign pwr_req_o = (st_q.ph == SQ_PWR_UP) || (st_q.on && st_q.ph != SQ_PWR_DN);
    assign cur_o     = st_q.cur;

    for (genvar k = 0; k < MODS; k++) begin : g_mod_out
        assign clk_en_o[k] = (st_q.cur[k] == MS_ENABLE);
        assign mrst_n_o[k] = rls_i[k] && st_q.cur[k][1];
    end

    // Clock may only run in a powered domain
    p_clk_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_o != '0) |-> dom_on_o);

    // Modules only move while the domain sequences
    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(st_q.cur));

    // Power flag only moves inside a transition
    p_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(dom_on_o));

    // Busy only rises from an accepted command
    p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // Module walk runs with power present
    p_walk_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == SQ_WALK) |-> pwr_req_o);

endmodule

// File: rtl/psc_regs.sv
module psc_regs
    import psc_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int MPD     = 2,
    parameter int AW      = 12,
    parameter int DW      = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_i,
    input  logic [AW-1:0]                   addr_i,
    input  logic [DW-1:0]                   wdata_i,
    output logic [DW-1:0]                   rdata_o,
    input  logic [NUM_DOM-1:0]              busy_i,
    input  logic [NUM_DOM-1:0]              dom_on_i,
    input  logic [NUM_DOM*MPD-1:0][1:0]     cur_i,
    input  logic [NUM_DOM*MPD-1:0]          clk_en_i,
    output logic [NUM_DOM-1:0]              start_o,
    output logic [NUM_DOM*MPD-1:0][1:0]     tgt_o,
    output logic [NUM_DOM*MPD-1:0]          rls_o,
    output logic [NUM_DOM-1:0]              keep_o
);

    localparam int NUM_MOD = NUM_DOM * MPD;

    typedef struct packed {
        logic [NUM_MOD-1:0][1:0] tgt;
        logic [NUM_MOD-1:0]      rls;
        logic [NUM_DOM-1:0]      keep;
    } reg_st_t;

    reg_st_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_i) begin
            for (int m = 0; m < NUM_MOD; m++) begin
                if (addr_i == AW'(MCTL_OFS + REG_STRIDE * m)) begin
                    rg_d.tgt[m] = wdata_i[1:0];
                    rg_d.rls[m] = wdata_i[MCTL_RLS_BIT];
                end
            end
            for (int d = 0; d < NUM_DOM; d++) begin
                if (addr_i == AW'(DCTL_OFS + REG_STRIDE * d)) begin
                    rg_d.keep[d] = wdata_i[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.tgt  <= '0;
            rg_q.rls  <= '1;
            rg_q.keep <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        start_o = '0;
        if (wr_i && addr_i == AW'(CMD_OFS)) begin
            start_o = wdata_i[NUM_DOM-1:0] & ~busy_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(BUSY_OFS)) begin
            rdata_o[NUM_DOM-1:0] = busy_i;
        end
        for (int d = 0; d < NUM_DOM; d++) begin
            if (addr_i == AW'(DSTAT_OFS + REG_STRIDE * d)) begin
                rdata_o[0] = dom_on_i[d];
            end
            if (addr_i == AW'(DCTL_OFS + REG_STRIDE * d)) begin
                rdata_o[0] = rg_q.keep[d];
            end
        end
        for (int m = 0; m < NUM_MOD; m++) begin
            if (addr_i == AW'(MSTAT_OFS + REG_STRIDE * m)) begin
                rdata_o[1:0]           = cur_i[m];
                rdata_o[MSTAT_CLK_BIT] = clk_en_i[m];
            end
            if (addr_i == AW'(MCTL_OFS + REG_STRIDE * m)) begin
                rdata_o[1:0]          = rg_q.tgt[m];
                rdata_o[MCTL_RLS_BIT] = rg_q.rls[m];
            end
        end
    end

    assign tgt_o  = rg_q.tgt;
    assign rls_o  = rg_q.rls;
    assign keep_o = rg_q.keep;

    // Bits above the widest field never read back as 1
    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DW-1:MSTAT_CLK_BIT+1] == '0);

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import psc_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int MPD     = 2,
    parameter int SETTLE  = 4,
    parameter int STEP    = 3,
    parameter int AW      = 12,
    parameter int DW      = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    output logic [NUM_DOM*MPD-1:0]   mod_clk_en,
    output logic [NUM_DOM*MPD-1:0]   mod_rst_n,
    output logic [NUM_DOM-1:0]       dom_pwr_req
);

    localparam int NUM_MOD = NUM_DOM * MPD;

    logic [NUM_DOM-1:0]          start;
    logic [NUM_DOM-1:0]          busy;
    logic [NUM_DOM-1:0]          dom_on;
    logic [NUM_DOM-1:0]          keep;
    logic [NUM_MOD-1:0][1:0]     tgt;
    logic [NUM_MOD-1:0][1:0]     cur;
    logic [NUM_MOD-1:0]          rls;

    psc_regs #(
        .NUM_DOM (NUM_DOM),
        .MPD     (MPD),
        .AW      (AW),
        .DW      (DW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .rdata_o  (bus_rdata),
        .busy_i   (busy),
        .dom_on_i (dom_on),
        .cur_i    (cur),
        .clk_en_i (mod_clk_en),
        .start_o  (start),
        .tgt_o    (tgt),
        .rls_o    (rls),
        .keep_o   (keep)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        psc_dom_seq #(
            .MODS   (MPD),
            .SETTLE (SETTLE),
            .STEP   (STEP)
        ) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start[d]),
            .tgt_i     (tgt[d*MPD +: MPD]),
            .rls_i     (rls[d*MPD +: MPD]),
            .keep_on_i (keep[d]),
            .busy_o    (busy[d]),
            .dom_on_o  (dom_on[d]),
            .pwr_req_o (dom_pwr_req[d]),
            .cur_o     (cur[d*MPD +: MPD]),
            .clk_en_o  (mod_clk_en[d*MPD +: MPD]),
            .mrst_n_o  (mod_rst_n[d*MPD +: MPD])
        );
    end

endmodule

// File: tb/sim_pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_sleep_ctrl;

    localparam int ND = 4;
    localparam int MP = 2;
    localparam int NM = ND * MP;
    localparam int SETTLE = 4;
    localparam int STEP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NM-1:0] mod_clk_en;
    logic [NM-1:0] mod_rst_n;
    logic [ND-1:0] dom_pwr_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int   exp_state [NM];
    bit   exp_on    [ND];
    int   reg_tgt   [NM];
    bit   reg_rls   [NM];

    always #2.5 clk = ~clk;

    pwr_sleep_ctrl #(.NUM_DOM(ND), .MPD(MP), .SETTLE(SETTLE), .STEP(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_clk_en(mod_clk_en),
        .mod_rst_n(mod_rst_n), .dom_pwr_req(dom_pwr_req)
    );

    function automatic int busy_len(bit pu, bit pd);
        return (pu ? SETTLE : 0) + MP * STEP + (pd ? SETTLE : 0);
    endfunction

    function automatic logic [31:0] mstat_val(int st);
        return {19'd0, (st == 3), 10'd0, 2'(st)};
    endfunction

    function automatic logic [31:0] mctl_val(int t, bit r);
        return {23'd0, r, 6'd0, 2'(t)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bwrite(int a, logic [31:0] v);
        @(negedge clk);
        bus_addr = 12'(a); bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bread(int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = 12'(a);
        #1 v = bus_rdata;
    endtask

    task automatic poll_busy(int d, output int n);
        logic [31:0] v;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            bread(32'h128, v);
            if (!v[d]) break;
            n++;
        end
    endtask

    task automatic sweep();
        logic [31:0] v;
        for (int m = 0; m < NM; m++) begin
            bread(32'h800 + 4*m, v);
            check("R7/R8/R12 module status", v, mstat_val(exp_state[m]));
            bread(32'hA00 + 4*m, v);
            check("R3 module control readback", v, mctl_val(reg_tgt[m], reg_rls[m]));
            check("R8 clock enable pin", 32'(mod_clk_en[m]), 32'(exp_state[m] == 3));
            check("R9 reset pin", 32'(mod_rst_n[m]), 32'(reg_rls[m] && exp_state[m] >= 2));
        end
        for (int d = 0; d < ND; d++) begin
            bread(32'h200 + 4*d, v);
            check("R6/R10 domain status", v, 32'(exp_on[d]));
            check("R6/R10 power request pin", 32'(dom_pwr_req[d]), 32'(exp_on[d]));
        end
    endtask

    task automatic set_targets(int d, int t0, int t1, bit r0, bit r1, bit keep);
        reg_tgt[d*MP] = t0; reg_rls[d*MP] = r0;
        reg_tgt[d*MP+1] = t1; reg_rls[d*MP+1] = r1;
        bwrite(32'hA00 + 4*(d*MP), mctl_val(t0, r0));
        bwrite(32'hA00 + 4*(d*MP+1), mctl_val(t1, r1));
        bwrite(32'h300 + 4*d, 32'(keep));
    endtask

    task automatic run_trans(int d, int t0, int t1, bit r0, bit r1, bit keep);
        int n;
        bit pu, pd;
        set_targets(d, t0, t1, r0, r1, keep);
        pu = !exp_on[d];
        pd = !keep && t0 == 0 && t1 == 0;
        bwrite(32'h120, 32'(1 << d));
        poll_busy(d, n);
        check("R4 busy length", 32'(n), 32'(busy_len(pu, pd)));
        exp_state[d*MP] = t0;
        exp_state[d*MP+1] = t1;
        exp_on[d] = !pd;
        sweep();
    endtask

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'h1F3A));
        for (int m = 0; m < NM; m++) begin
            exp_state[m] = 0; reg_tgt[m] = 0; reg_rls[m] = 1'b1;
        end
        for (int d = 0; d < ND; d++) exp_on[d] = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 clock enables", 32'(mod_clk_en), 32'd0);
        check("R1 module resets", 32'(mod_rst_n), 32'd0);
        check("R1 power requests", 32'(dom_pwr_req), 32'd0);
        bread(32'h128, v);
        check("R1 busy status", v, 32'd0);
        sweep();

        // R11 unmapped offsets and R2 map edges
        bread(32'h124, v); check("R11 unmapped 0x124", v, 32'd0);
        bread(32'h400, v); check("R11 unmapped 0x400", v, 32'd0);
        bread(32'h820, v); check("R11 past last module 0x820", v, 32'd0);
        bread(32'hFFC, v); check("R11 unmapped 0xFFC", v, 32'd0);
        bread(32'h120, v); check("R2 command reads zero", v, 32'd0);

        // R3 reserved bits in module control
        bwrite(32'hA08, 32'hFFFF_FFFF);
        bread(32'hA08, v); check("R3 all-ones write", v, 32'h0000_0103);
        bwrite(32'hA08, 32'h0000_0100);

        // Directed transitions
        run_trans(0, 3, 2, 1'b1, 1'b1, 1'b1);   // R6 power-up
        run_trans(0, 3, 3, 1'b1, 1'b0, 1'b1);   // R4 no power-up, R9 held reset
        run_trans(1, 1, 0, 1'b1, 1'b1, 1'b0);   // not all zero: stays on
        run_trans(1, 0, 0, 1'b1, 1'b1, 1'b0);   // R10 power-down
        run_trans(2, 0, 0, 1'b1, 1'b1, 1'b0);   // R10 up then down
        run_trans(2, 2, 3, 1'b0, 1'b1, 1'b1);   // R9 local reset

        // R5 command to busy domain ignored, late control write has no effect
        set_targets(3, 3, 3, 1'b1, 1'b1, 1'b1);
        bwrite(32'h120, 32'h8);
        bwrite(32'h120, 32'h8);
        reg_tgt[6] = 1; reg_rls[6] = 1'b1;
        bwrite(32'hA18, mctl_val(1, 1'b1));
        poll_busy(3, n);
        check("R5 retrigger ignored", 32'(n), 32'(busy_len(1'b1, 1'b0) - 2));
        exp_state[6] = 3; exp_state[7] = 3; exp_on[3] = 1'b1;
        sweep();

        // Random transitions
        for (int it = 0; it < 40; it++) begin
            int d, t0, t1;
            bit r0, r1, kp;
            d  = int'($urandom % ND);
            t0 = int'($urandom % 4);
            t1 = int'($urandom % 4);
            if ($urandom % 4 == 0) begin t0 = 0; t1 = 0; end
            r0 = 1'($urandom);
            r1 = 1'($urandom);
            kp = 1'($urandom);
            run_trans(d, t0, t1, r0, r1, kp);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule